// File: doc/BRIEF.md
# Fuse-Configured AND-OR Logic Plane

This block is the programmable core of a small registered-logic device: a wired AND plane followed by fixed OR groups. Twenty-two input signals each enter the plane twice, once true and once inverted, to give 44 literal columns. There are 132 product rows. A row is the AND of the literals whose fuses are set. Most rows are grouped into ten sum terms of unequal size. Each output group also owns one enable row. Two further rows give the shared register-control terms, one for asynchronous clear and one for synchronous preset.

The whole configuration arrives as one serial stream, one bit per clock, in a fixed fuse numbering. The array fuses come first, row after row, with 44 per row. Next come two mode bits per output. Two spare positions are skipped. Last come two drive bits per output. After the final bit the block raises a done flag and starts evaluating. From then on, every output follows the inputs combinationally. The mode and drive bits are passed through unchanged for the output cells that sit downstream.

Top module: `sop_array`

## Requirements
- R1: While reset is asserted (rst_ni low, asynchronous) and after it is released, cfg_done_o is 0 and every evaluated and configuration output is 0 until loading completes.
- R2: Each clock edge with cfg_valid_i high, while not done, stores cfg_bit_i at the next fuse number. Numbering starts at 0 and advances by one per accepted bit. cfg_done_o rises at the edge that accepts fuse 5849, which is the 5850th bit.
- R3: Once cfg_done_o is high it stays high until reset. Further cfg_valid_i pulses change no fuse and no output.
- R4: Row r uses fuses 44r to 44r+43. Within a row, column 2i is sig_i[i] true and column 2i+1 is sig_i[i] inverted. A fuse value of 1 connects that literal. A row with no connection evaluates to 1. A row connecting both literals of one input evaluates to 0.
- R5: Row 0 drives arst_term_o and row 131 drives spre_term_o.
- R6: Rows 1 to 130 form ten consecutive groups, one per output k from 0 to 9, holding 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 logic rows. In each group the first row drives oe_o[k] and the remaining rows are ORed into sum_o[k].
- R7: arch_o[j] equals fuse 5808+j for j from 0 to 19, so output k has bits 2k and 2k+1. drive_o[j] equals fuse 5830+j. Fuses 5828 and 5829 affect no output.
- R8: While cfg_done_o is 0, sum_o, oe_o, arst_term_o, spre_term_o, arch_o and drive_o are all 0.
- R9: Once done, the evaluated outputs respond to a change on sig_i within the same clock cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the fuse loader |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_valid_i | input | 1 | Serial fuse bit present |
| cfg_bit_i | input | 1 | Serial fuse value |
| sig_i | input | 22 | Array input signals |
| cfg_done_o | output | 1 | All fuses loaded |
| sum_o | output | 10 | Per-output OR of logic rows |
| oe_o | output | 10 | Per-output enable row |
| arst_term_o | output | 1 | Shared asynchronous-clear row |
| spre_term_o | output | 1 | Shared synchronous-preset row |
| arch_o | output | 20 | Per-output mode bit pairs |
| drive_o | output | 20 | Per-output slew and open-drain bit pairs |

## Verification
The final fuse write and the switch from gated to live outputs fall on the same clock edge. The bit at fuse 5849 is the last drive bit, and that same edge raises cfg_done_o. To test this, the bench gives that last bit the value 1 and compares drive_o, the sums and the global terms at the next falling edge against a behavioural model. A second overlap happens when cfg_valid_i stays high after loading while sig_i keeps changing. The outputs must follow only the inputs, and the frozen configuration bits must not move.

// File: rtl/sop_pkg.sv
package sop_pkg;

    // Logic rows given to output k: grows by two toward the centre, then shrinks.
    function automatic int terms_of(input int k, input int n_out, input int min_t);
        return (k < n_out / 2) ? (min_t + 2 * k) : (min_t + 2 * (n_out - 1 - k));
    endfunction

    // First row (the enable row) of output k's group; row 0 is the clear term.
    function automatic int group_base(input int k, input int n_out, input int min_t);
        int b;
        b = 1;
        for (int j = 0; j < k; j++) begin
            b += terms_of(j, n_out, min_t) + 1;
        end
        return b;
    endfunction

    // All groups plus the clear row and the preset row.
    function automatic int row_total(input int n_out, input int min_t);
        return group_base(n_out, n_out, min_t) + 1;
    endfunction

endpackage

// File: rtl/sop_fuse_loader.sv
module sop_fuse_loader #(
    parameter int ROWS  = 132,
    parameter int COLS  = 44,
    parameter int N_OUT = 10,
    parameter int GAP   = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  cfg_valid_i,
    input  logic                  cfg_bit_i,
    output logic [ROWS*COLS-1:0]  arr_o,
    output logic [2*N_OUT-1:0]    arch_o,
    output logic [2*N_OUT-1:0]    drive_o,
    output logic                  done_o
);
    localparam int ARR_N    = ROWS * COLS;
    localparam int CFG_W    = 2 * N_OUT;
    localparam int DRV_BASE = ARR_N + CFG_W + GAP;
    localparam int TOTAL    = DRV_BASE + CFG_W;
    localparam int CW       = $clog2(TOTAL);
    localparam int AIW      = $clog2(ARR_N);
    localparam int CIW      = $clog2(CFG_W);

    localparam logic [CW-1:0] ARCH_AT = CW'(ARR_N);
    localparam logic [CW-1:0] GAP_AT  = CW'(ARR_N + CFG_W);
    localparam logic [CW-1:0] DRV_AT  = CW'(DRV_BASE);
    localparam logic [CW-1:0] LAST_AT = CW'(TOTAL - 1);

    typedef struct packed {
        logic [ARR_N-1:0] arr;
        logic [CFG_W-1:0] arch;
        logic [CFG_W-1:0] drv;
        logic [CW-1:0]    idx;
        logic             done;
    } ld_t;

    ld_t ld_d, ld_q;

    always_comb begin
        ld_d = ld_q;
        if (cfg_valid_i && !ld_q.done) begin
            if (ld_q.idx < ARCH_AT) begin
                ld_d.arr[AIW'(ld_q.idx)] = cfg_bit_i;
            end else if (ld_q.idx < GAP_AT) begin
                ld_d.arch[CIW'(ld_q.idx - ARCH_AT)] = cfg_bit_i;
            end else if (ld_q.idx >= DRV_AT) begin
                ld_d.drv[CIW'(ld_q.idx - DRV_AT)] = cfg_bit_i;
            end
            ld_d.idx = ld_q.idx + CW'(1);
            if (ld_q.idx == LAST_AT) begin
                ld_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ld_q <= '0;
        end else begin
            ld_q <= ld_d;
        end
    end

    assign arr_o   = ld_q.arr;
    assign arch_o  = ld_q.arch;
    assign drive_o = ld_q.drv;
    assign done_o  = ld_q.done;

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
    parameter int N_IN = 22,
    parameter int ROWS = 132
) (
    input  logic [N_IN-1:0]           sig_i,
    input  logic [ROWS*2*N_IN-1:0]    arr_i,
    output logic [ROWS-1:0]           row_o
);
    localparam int COLS = 2 * N_IN;

    logic [COLS-1:0] lit;

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lit[2*i]   = sig_i[i];
        assign lit[2*i+1] = ~sig_i[i];
    end

    // A row passes when every connected literal is high.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_o[r] = &(~arr_i[r*COLS +: COLS] | lit);
    end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
    parameter int N_OUT     = 10,
    parameter int MIN_TERMS = 8,
    parameter int ROWS      = 132
) (
    input  logic [ROWS-1:0]  row_i,
    input  logic             en_i,
    output logic [N_OUT-1:0] sum_o,
    output logic [N_OUT-1:0] oe_o,
    output logic             arst_o,
    output logic             spre_o
);
    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        localparam int BASE = sop_pkg::group_base(k, N_OUT, MIN_TERMS);
        localparam int NT   = sop_pkg::terms_of(k, N_OUT, MIN_TERMS);
        assign oe_o[k]  = en_i & row_i[BASE];
        assign sum_o[k] = en_i & (|row_i[BASE+1 +: NT]);
    end

    assign arst_o = en_i & row_i[0];
    assign spre_o = en_i & row_i[ROWS-1];

endmodule

// File: rtl/sop_array.sv
module sop_array #(
    parameter int N_IN      = 22,
    parameter int N_OUT     = 10,
    parameter int MIN_TERMS = 8,
    parameter int GAP       = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cfg_valid_i,
    input  logic               cfg_bit_i,
    input  logic [N_IN-1:0]    sig_i,
    output logic               cfg_done_o,
    output logic [N_OUT-1:0]   sum_o,
    output logic [N_OUT-1:0]   oe_o,
    output logic               arst_term_o,
    output logic               spre_term_o,
    output logic [2*N_OUT-1:0] arch_o,
    output logic [2*N_OUT-1:0] drive_o
);
    localparam int COLS = 2 * N_IN;
    localparam int ROWS = sop_pkg::row_total(N_OUT, MIN_TERMS);

    logic [ROWS*COLS-1:0] arr;
    logic [2*N_OUT-1:0]   arch_raw;
    logic [2*N_OUT-1:0]   drive_raw;
    logic                 done;
    logic [ROWS-1:0]      rows;

    sop_fuse_loader #(
        .ROWS (ROWS),
        .COLS (COLS),
        .N_OUT(N_OUT),
        .GAP  (GAP)
    ) i_loader (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cfg_valid_i(cfg_valid_i),
        .cfg_bit_i  (cfg_bit_i),
        .arr_o      (arr),
        .arch_o     (arch_raw),
        .drive_o    (drive_raw),
        .done_o     (done)
    );

    sop_and_plane #(
        .N_IN(N_IN),
        .ROWS(ROWS)
    ) i_and (
        .sig_i(sig_i),
        .arr_i(arr),
        .row_o(rows)
    );

    sop_or_plane #(
        .N_OUT    (N_OUT),
        .MIN_TERMS(MIN_TERMS),
        .ROWS     (ROWS)
    ) i_or (
        .row_i (rows),
        .en_i  (done),
        .sum_o (sum_o),
        .oe_o  (oe_o),
        .arst_o(arst_term_o),
        .spre_o(spre_term_o)
    );

    assign cfg_done_o = done;
    assign arch_o     = done ? arch_raw  : '0;
    assign drive_o    = done ? drive_raw : '0;

endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
    parameter int N_IN  = 22,
    parameter int N_OUT = 10
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               cfg_valid_i,
    input logic [N_IN-1:0]    sig_i,
    input logic               cfg_done_o,
    input logic [N_OUT-1:0]   sum_o,
    input logic [N_OUT-1:0]   oe_o,
    input logic               arst_term_o,
    input logic               spre_term_o,
    input logic [2*N_OUT-1:0] arch_o,
    input logic [2*N_OUT-1:0] drive_o
);
    // R2
    done_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cfg_done_o) |-> $past(cfg_valid_i));

    // R3
    done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_done_o |=> cfg_done_o);

    // R3
    cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_done_o |=> ($stable(arch_o) && $stable(drive_o)));

    // R8
    gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_done_o |-> (sum_o == '0 && oe_o == '0 && !arst_term_o && !spre_term_o
                         && arch_o == '0 && drive_o == '0));

    // R9
    pure_comb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_done_o && $past(cfg_done_o) && $stable(sig_i)) |->
        ($stable(sum_o) && $stable(oe_o) && $stable(arst_term_o) && $stable(spre_term_o)));

endmodule

bind sop_array sop_array_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_valid_i(cfg_valid_i),
    .sig_i      (sig_i),
    .cfg_done_o (cfg_done_o),
    .sum_o      (sum_o),
    .oe_o       (oe_o),
    .arst_term_o(arst_term_o),
    .spre_term_o(spre_term_o),
    .arch_o     (arch_o),
    .drive_o    (drive_o)
);

// File: tb/test_sop_array.sv
`timescale 1ns/1ps
module test_sop_array;
    localparam int NF    = 5850;
    localparam int NROW  = 132;
    localparam int NCOL  = 44;
    localparam int ARCHB = 5808;
    localparam int DRVB  = 5830;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic        cfg_bit = 1'b0;
    logic [21:0] sig = '0;
    logic        done;
    logic [9:0]  sum, oe;
    logic        arst, spre;
    logic [19:0] arch, drive;

    int errors = 0;
    int checks = 0;
    bit cmp_en = 0;

    bit img [NF];
    bit mdl [NF];
    int mdl_cnt = 0;
    bit mdl_done = 0;
    int tcnt [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

    logic [9:0]  e_sum, e_oe;
    logic        e_arst, e_spre;
    logic [19:0] e_arch, e_drive;

    always #10 clk = ~clk;

    sop_array i_sop_array (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .cfg_valid_i(cfg_valid),
        .cfg_bit_i  (cfg_bit),
        .sig_i      (sig),
        .cfg_done_o (done),
        .sum_o      (sum),
        .oe_o       (oe),
        .arst_term_o(arst),
        .spre_term_o(spre),
        .arch_o     (arch),
        .drive_o    (drive)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit row_val(int r);
        bit v = 1;
        for (int c = 0; c < NCOL; c++) begin
            if (mdl[r*NCOL + c]) v &= (c % 2 == 1) ? ~sig[c/2] : sig[c/2];
        end
        return v;
    endfunction

    task automatic model_eval();
        int r;
        e_sum = '0; e_oe = '0; e_arst = 0; e_spre = 0; e_arch = '0; e_drive = '0;
        if (mdl_done) begin
            e_arst = row_val(0);
            e_spre = row_val(NROW - 1);
            r = 1;
            for (int k = 0; k < 10; k++) begin
                e_oe[k] = row_val(r);
                r++;
                for (int t = 0; t < tcnt[k]; t++) begin
                    if (row_val(r)) e_sum[k] = 1'b1;
                    r++;
                end
            end
            for (int j = 0; j < 20; j++) begin
                e_arch[j]  = mdl[ARCHB + j];
                e_drive[j] = mdl[DRVB + j];
            end
        end
    endtask

    // Reference loader: follows R2/R3 behaviourally.
    always @(posedge clk) begin
        if (!rst_n) begin
            mdl_cnt = 0;
            mdl_done = 0;
            foreach (mdl[i]) mdl[i] = 0;
        end else if (cfg_valid && !mdl_done) begin
            mdl[mdl_cnt] = cfg_bit;
            mdl_cnt++;
            if (mdl_cnt == NF) mdl_done = 1;
        end
    end

    // Compare on every clock, away from the rising edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            string g;
            model_eval();
            g = mdl_done ? "R6" : "R8";
            chk("R2", "cfg_done", {31'd0, done}, {31'd0, mdl_done});
            chk(g, "sum", {22'd0, sum}, {22'd0, e_sum});
            chk(g, "oe", {22'd0, oe}, {22'd0, e_oe});
            chk(mdl_done ? "R5" : "R8", "arst/spre", {30'd0, arst, spre}, {30'd0, e_arst, e_spre});
            chk(mdl_done ? "R7" : "R8", "arch", {12'd0, arch}, {12'd0, e_arch});
            chk(mdl_done ? "R7" : "R8", "drive", {12'd0, drive}, {12'd0, e_drive});
        end
    end

    task automatic build_image();
        int r;
        foreach (img[i]) img[i] = 0;
        for (r = 0; r < NROW; r++) begin
            int nl = 1 + ($urandom % 3);
            for (int n = 0; n < nl; n++) img[r*NCOL + ($urandom % NCOL)] = 1;
        end
        // R5: clear row is sig[0] true, preset row is sig[1] inverted
        for (int c = 0; c < NCOL; c++) begin
            img[c] = (c == 0);
            img[(NROW-1)*NCOL + c] = (c == 3);
        end
        // R4: enable row of output 0 (row 1) has both literals of sig[2]; output 1 enable (row 10) empty
        for (int c = 0; c < NCOL; c++) begin
            img[1*NCOL + c]  = (c == 4) || (c == 5);
            img[10*NCOL + c] = 0;
        end
        for (int j = 0; j < 20; j++) begin
            img[ARCHB + j] = $urandom % 2;
            img[DRVB + j]  = $urandom % 2;
        end
        img[ARCHB + 20] = 1;  // spare fuses, R7
        img[ARCHB + 21] = 1;
        img[NF - 1] = 1;      // last bit lands with done
    endtask

    task automatic set_sig(input logic [21:0] v);
        @(posedge clk);
        #2 sig = v;
    endtask

    initial begin : watchdog
        #(20ns * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        build_image();
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        cmp_en = 1;
        @(negedge clk);
        // R1
        chk("R1", "done after reset", {31'd0, done}, 32'd0);
        chk("R1", "sum after reset", {22'd0, sum}, 32'd0);
        chk("R1", "arch after reset", {12'd0, arch}, 32'd0);
        // R8: inputs moving before configuration
        for (int i = 0; i < 5; i++) set_sig(22'($urandom));
        // R2: serial load
        for (int i = 0; i < NF; i++) begin
            @(posedge clk);
            #2 cfg_valid = 1'b1;
            cfg_bit = img[i];
            if (i == NF - 1) begin
                #6 chk("R2", "done before last bit", {31'd0, done}, 32'd0);
            end
        end
        @(posedge clk);
        #2 cfg_valid = 1'b0;
        #1 chk("R2", "done after last bit", {31'd0, done}, 32'd1);
        chk("R7", "drive bit 19 from last fuse", {31'd0, drive[19]}, 32'd1);
        // R4/R5 directed
        set_sig('0);
        #3;
        chk("R4", "both literals row is 0", {31'd0, oe[0]}, 32'd0);
        chk("R4", "empty row is 1", {31'd0, oe[1]}, 32'd1);
        chk("R5", "clear term with sig0=0", {31'd0, arst}, 32'd0);
        chk("R5", "preset term with sig1=0", {31'd0, spre}, 32'd1);
        set_sig('1);
        #3;
        chk("R4", "both literals row all ones", {31'd0, oe[0]}, 32'd0);
        chk("R5", "clear term with sig0=1", {31'd0, arst}, 32'd1);
        chk("R5", "preset term with sig1=1", {31'd0, spre}, 32'd0);
        // R9: same-cycle response, walking ones
        for (int b = 0; b < 22; b++) begin
            set_sig(22'(1) << b);
            #3 model_eval();
            chk("R9", "sum same cycle", {22'd0, sum}, {22'd0, e_sum});
        end
        for (int i = 0; i < 150; i++) set_sig(22'($urandom));
        // R3: writes after done are ignored
        for (int i = 0; i < 40; i++) begin
            @(posedge clk);
            #2 cfg_valid = 1'b1;
            cfg_bit = ~cfg_bit;
            sig = 22'($urandom);
        end
        @(posedge clk);
        #2 cfg_valid = 1'b0;
        #3 chk("R3", "done held", {31'd0, done}, 32'd1);
        model_eval();
        chk("R3", "arch unchanged", {12'd0, arch}, {12'd0, e_arch});
        chk("R3", "drive unchanged", {12'd0, drive}, {12'd0, e_drive});
        for (int i = 0; i < 20; i++) set_sig(22'($urandom));
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule